// File: doc/BRIEF.md
# Programmable Video Sync and Blank Pins

This block drives two multi-function video pins from the signals of on-chip video timers. The first pin is always an output and carries a blanking signal. The second pin changes both its function and its direction. A few configuration bits choose between two pairings.

In composite-sync mode, the first pin carries blanking for both retrace directions. The second pin then works in one of two ways. As an output, it drives an active-low composite sync built from the timer sync signals or from externally supplied sync signals. As an input, it receives a composite-sync stream, and the block splits that stream back into separate horizontal and vertical sync events. In separate-sync mode, the first pin carries vertical blanking and the second pin drives horizontal blanking.

Sync recovery works by measuring each low pulse on the input. A pulse longer than a programmable threshold counts as vertical sync, and any other pulse counts as horizontal sync. The result comes out as a one-cycle strobe on the matching output.

Top module: `vid_sync_pins`

## Requirements
- R1: While rst_n is low, pin_a_oe=1, pin_a_o=0, pin_b_oe=0 (second pin is an input) and pin_b_o=1, and no recovered strobe is raised.
- R2: With cfg_composite=1, pin_a_o equals tmr_hblank OR tmr_vblank as sampled at the previous clock edge.
- R3: With cfg_composite=0, pin_a_o equals tmr_vblank as sampled at the previous clock edge, and horizontal blanking has no effect on it.
- R4: With cfg_composite=0, pin_b_oe=1 and pin_b_o equals tmr_hblank as sampled at the previous clock edge.
- R5: With cfg_composite=1 and cfg_csync_out=1, pin_b_oe=1 and pin_b_o is 0 whenever the selected horizontal or vertical sync was 1 at the previous edge, and 1 otherwise.
- R6: cfg_ext_sync=1 takes the sync pair that forms the composite-sync output from ext_hsync/ext_vsync. cfg_ext_sync=0 takes it from tmr_hsync/tmr_vsync, and the unselected pair has no effect.
- R7: With cfg_composite=1 and cfg_csync_out=0, pin_b_oe=0.
- R8: In input mode (R7), a low pulse of L cycles on pin_b_i produces one strobe. The strobe is a one-cycle rec_vsync if L > cfg_vs_thresh and a one-cycle rec_hsync otherwise. It is high during the second cycle after pin_b_i returns high, and the two strobes are never high together.
- R9: Outside input mode, pulses on pin_b_i produce no strobe on rec_hsync or rec_vsync.
- R10: A change of the mode or direction bits shows at the pins after the next clock edge, not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_composite | input | 1 | 1 = composite-sync mode, 0 = separate-sync mode |
| cfg_csync_out | input | 1 | Composite mode only: 1 = second pin drives composite sync, 0 = second pin receives it |
| cfg_ext_sync | input | 1 | 1 = composite sync formed from the external sync pair |
| cfg_vs_thresh | input | CNT_W | Pulse-width threshold in cycles for vertical sync |
| tmr_hsync | input | 1 | Timer horizontal sync, active high |
| tmr_vsync | input | 1 | Timer vertical sync, active high |
| tmr_hblank | input | 1 | Timer horizontal blanking, active high |
| tmr_vblank | input | 1 | Timer vertical blanking, active high |
| ext_hsync | input | 1 | External horizontal sync, active high |
| ext_vsync | input | 1 | External vertical sync, active high |
| pin_b_i | input | 1 | Second pin input value |
| pin_a_o | output | 1 | First pin drive value |
| pin_a_oe | output | 1 | First pin output enable |
| pin_b_o | output | 1 | Second pin drive value |
| pin_b_oe | output | 1 | Second pin output enable |
| rec_hsync | output | 1 | Recovered horizontal sync strobe |
| rec_vsync | output | 1 | Recovered vertical sync strobe |

## Verification
A direction change on the second pin and the end of a recovered pulse can fall on the same clock edge. The pin turns to an output in the same cycle as a pulse it was measuring is about to produce its strobe. The bench provokes this by leaving input mode right after a pulse ends. It also sends pulses while the pin acts as an output. A scoreboard holds only the strobes that input-mode pulses should produce. Any strobe that comes out without a matching expected entry is reported as a failure against R9.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
    typedef struct packed {
        logic a_o;
        logic b_o;
        logic b_oe;
    } pin_state_t;

    localparam pin_state_t PIN_RST = '{a_o: 1'b0, b_o: 1'b1, b_oe: 1'b0};
endpackage

// File: rtl/vsb_pin_mux.sv
module vsb_pin_mux
    import vsb_pkg::*;
(
    input  logic       composite,
    input  logic       csync_out,
    input  logic       ext_sel,
    input  logic       tmr_hs,
    input  logic       tmr_vs,
    input  logic       tmr_hb,
    input  logic       tmr_vb,
    input  logic       ext_hs,
    input  logic       ext_vs,
    output pin_state_t nxt
);
    logic hs_sel;
    logic vs_sel;
    logic csync_n;

    always_comb begin
        hs_sel  = ext_sel ? ext_hs : tmr_hs;
        vs_sel  = ext_sel ? ext_vs : tmr_vs;
        csync_n = ~(hs_sel | vs_sel);
        if (composite) begin
            nxt.a_o  = tmr_hb | tmr_vb;
            nxt.b_oe = csync_out;
            nxt.b_o  = csync_out ? csync_n : 1'b1;
        end else begin
            nxt.a_o  = tmr_vb;
            nxt.b_oe = 1'b1;
            nxt.b_o  = tmr_hb;
        end
    end
endmodule

// File: rtl/vsb_sync_recover.sv
module vsb_sync_recover #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] thr,
    input  logic             pin_i,
    output logic             hs_stb,
    output logic             vs_stb
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             smp;
        logic [CNT_W-1:0] cnt;
        logic             hs;
        logic             vs;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d    = rec_q;
        rec_d.hs = 1'b0;
        rec_d.vs = 1'b0;
        if (!en) begin
            rec_d.smp = 1'b1;
            rec_d.cnt = '0;
        end else begin
            rec_d.smp = pin_i;
            if (!rec_q.smp) begin
                if (rec_q.cnt != CNT_MAX) rec_d.cnt = rec_q.cnt + 1'b1;
            end else if (rec_q.cnt != '0) begin
                rec_d.vs  = (rec_q.cnt > thr);
                rec_d.hs  = !(rec_q.cnt > thr);
                rec_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '{smp: 1'b1, cnt: '0, hs: 1'b0, vs: 1'b0};
        else        rec_q <= rec_d;
    end

    assign hs_stb = rec_q.hs;
    assign vs_stb = rec_q.vs;
endmodule

// File: rtl/vid_sync_pins.sv
module vid_sync_pins
    import vsb_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_composite,
    input  logic             cfg_csync_out,
    input  logic             cfg_ext_sync,
    input  logic [CNT_W-1:0] cfg_vs_thresh,
    input  logic             tmr_hsync,
    input  logic             tmr_vsync,
    input  logic             tmr_hblank,
    input  logic             tmr_vblank,
    input  logic             ext_hsync,
    input  logic             ext_vsync,
    input  logic             pin_b_i,
    output logic             pin_a_o,
    output logic             pin_a_oe,
    output logic             pin_b_o,
    output logic             pin_b_oe,
    output logic             rec_hsync,
    output logic             rec_vsync
);
    pin_state_t pin_d, pin_q;
    logic       rx_mode;

    assign rx_mode = cfg_composite & ~cfg_csync_out;

    vsb_pin_mux u_mux (
        .composite (cfg_composite),
        .csync_out (cfg_csync_out),
        .ext_sel   (cfg_ext_sync),
        .tmr_hs    (tmr_hsync),
        .tmr_vs    (tmr_vsync),
        .tmr_hb    (tmr_hblank),
        .tmr_vb    (tmr_vblank),
        .ext_hs    (ext_hsync),
        .ext_vs    (ext_vsync),
        .nxt       (pin_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= PIN_RST;
        else        pin_q <= pin_d;
    end

    vsb_sync_recover #(.CNT_W(CNT_W)) u_rec (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (rx_mode),
        .thr    (cfg_vs_thresh),
        .pin_i  (pin_b_i),
        .hs_stb (rec_hsync),
        .vs_stb (rec_vsync)
    );

    assign pin_a_o  = pin_q.a_o;
    assign pin_a_oe = 1'b1;
    assign pin_b_o  = pin_q.b_o;
    assign pin_b_oe = pin_q.b_oe;
endmodule

// File: rtl/vid_sync_pins_chk.sv
module vid_sync_pins_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_composite,
    input logic cfg_csync_out,
    input logic tmr_hblank,
    input logic tmr_vblank,
    input logic pin_a_o,
    input logic pin_b_o,
    input logic pin_b_oe,
    input logic rec_hsync,
    input logic rec_vsync
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rec_hsync && rec_vsync)); // R8
    AST_VS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rec_vsync |=> !rec_vsync); // R8
    AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_composite && !cfg_csync_out) |=> !pin_b_oe); // R7
    AST_SEP_HBLANK: assert property (@(posedge clk) disable iff (!rst_n) !cfg_composite |=> (pin_b_oe && pin_b_o == $past(tmr_hblank))); // R4
    AST_SEP_VBLANK: assert property (@(posedge clk) disable iff (!rst_n) !cfg_composite |=> (pin_a_o == $past(tmr_vblank))); // R3
    AST_NO_STROBE_TX: assert property (@(posedge clk) disable iff (!rst_n) !(cfg_composite && !cfg_csync_out) |=> !(rec_hsync || rec_vsync)); // R9
endmodule

bind vid_sync_pins vid_sync_pins_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_composite (cfg_composite),
    .cfg_csync_out (cfg_csync_out),
    .tmr_hblank    (tmr_hblank),
    .tmr_vblank    (tmr_vblank),
    .pin_a_o       (pin_a_o),
    .pin_b_o       (pin_b_o),
    .pin_b_oe      (pin_b_oe),
    .rec_hsync     (rec_hsync),
    .rec_vsync     (rec_vsync)
);

// File: tb/vid_sync_pins_tb.sv
module vid_sync_pins_tb;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_composite = 1'b1, cfg_csync_out = 1'b0, cfg_ext_sync = 1'b0;
    logic [CW-1:0] cfg_vs_thresh = 12'd8;
    logic tmr_hsync = 0, tmr_vsync = 0, tmr_hblank = 0, tmr_vblank = 0;
    logic ext_hsync = 0, ext_vsync = 0, pin_b_i = 1'b1;
    logic pin_a_o, pin_a_oe, pin_b_o, pin_b_oe, rec_hsync, rec_vsync;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_q[$];   // {vsync, hsync}

    always #10 clk = ~clk;

    vid_sync_pins #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_composite(cfg_composite),
        .cfg_csync_out(cfg_csync_out), .cfg_ext_sync(cfg_ext_sync),
        .cfg_vs_thresh(cfg_vs_thresh), .tmr_hsync(tmr_hsync),
        .tmr_vsync(tmr_vsync), .tmr_hblank(tmr_hblank), .tmr_vblank(tmr_vblank),
        .ext_hsync(ext_hsync), .ext_vsync(ext_vsync), .pin_b_i(pin_b_i),
        .pin_a_o(pin_a_o), .pin_a_oe(pin_a_oe), .pin_b_o(pin_b_o),
        .pin_b_oe(pin_b_oe), .rec_hsync(rec_hsync), .rec_vsync(rec_vsync)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // driver: one low pulse of len cycles; pushes the expected strobe when recovery applies
    task automatic pulse(input int len, input bit expect_it);
        if (expect_it) exp_q.push_back((len > int'(cfg_vs_thresh)) ? 2'b10 : 2'b01);
        pin_b_i = 1'b0;
        repeat (len) @(negedge clk);
        pin_b_i = 1'b1;
    endtask

    // monitor: compares every strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n && (rec_hsync || rec_vsync)) begin
            logic [1:0] e;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected strobe actual=%b%b expected=00", rec_vsync, rec_hsync);
            end else begin
                e = exp_q.pop_front();
                if ({rec_vsync, rec_hsync} !== e) begin
                    errors++;
                    $display("FAIL R8 strobe actual=%b%b expected=%b", rec_vsync, rec_hsync, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset pins", {pin_a_oe, pin_a_o, pin_b_oe, pin_b_o}, 4'b1001);
        chk("R1 reset strobes", {2'b00, rec_vsync, rec_hsync}, 4'b0000);
        rst_n = 1'b1;

        // R2 composite blanking
        tmr_hblank = 1; @(negedge clk);
        chk("R2 hblank", {3'b0, pin_a_o}, 4'b0001);
        tmr_hblank = 0; tmr_vblank = 1; @(negedge clk);
        chk("R2 vblank", {3'b0, pin_a_o}, 4'b0001);
        tmr_vblank = 0; @(negedge clk);
        chk("R2 none", {3'b0, pin_a_o}, 4'b0000);
        chk("R7 input no drive", {3'b0, pin_b_oe}, 4'b0000);

        // R8 recovery, threshold 8
        pulse(3, 1); repeat (4) @(negedge clk);
        pulse(8, 1); repeat (4) @(negedge clk);
        pulse(9, 1); repeat (4) @(negedge clk);
        pulse(1, 1); repeat (4) @(negedge clk);
        chk("R8 scoreboard drained", 4'(exp_q.size()), 4'd0);

        // R10 direction change waits for the edge
        cfg_csync_out = 1'b1;
        #1 chk("R10 before edge", {3'b0, pin_b_oe}, 4'b0000);
        @(negedge clk);
        chk("R10 after edge", {3'b0, pin_b_oe}, 4'b0001);

        // R5 composite sync output
        chk("R5 idle high", {2'b0, pin_b_oe, pin_b_o}, 4'b0011);
        tmr_hsync = 1; @(negedge clk);
        chk("R5 hsync low", {3'b0, pin_b_o}, 4'b0000);
        tmr_hsync = 0; tmr_vsync = 1; @(negedge clk);
        chk("R5 vsync low", {3'b0, pin_b_o}, 4'b0000);
        tmr_vsync = 0;

        // R6 external source select
        ext_hsync = 1; @(negedge clk);
        chk("R6 ext unselected", {3'b0, pin_b_o}, 4'b0001);
        cfg_ext_sync = 1; @(negedge clk);
        chk("R6 ext hsync", {3'b0, pin_b_o}, 4'b0000);
        ext_hsync = 0; tmr_vsync = 1; @(negedge clk);
        chk("R6 timer ignored", {3'b0, pin_b_o}, 4'b0001);
        tmr_vsync = 0; ext_vsync = 1; @(negedge clk);
        chk("R6 ext vsync", {3'b0, pin_b_o}, 4'b0000);
        ext_vsync = 0;

        // R9 pulses while output produce nothing
        pulse(12, 0); repeat (4) @(negedge clk);

        // R3/R4 separate mode
        cfg_composite = 0; tmr_hblank = 1; @(negedge clk);
        chk("R3 hblank ignored", {3'b0, pin_a_o}, 4'b0000);
        chk("R4 hblank on pin b", {2'b0, pin_b_oe, pin_b_o}, 4'b0011);
        tmr_hblank = 0; tmr_vblank = 1; @(negedge clk);
        chk("R3 vblank", {3'b0, pin_a_o}, 4'b0001);
        chk("R4 hblank low", {2'b0, pin_b_oe, pin_b_o}, 4'b0010);
        tmr_vblank = 0;
        pulse(10, 0); repeat (4) @(negedge clk);

        // R9 leaving input mode as a pulse ends: strobe is dropped
        cfg_composite = 1; cfg_csync_out = 0; @(negedge clk);
        pulse(5, 0);
        cfg_csync_out = 1;
        repeat (4) @(negedge clk);
        chk("R9 no pending", 4'(exp_q.size()), 4'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule